// File: doc/BRIEF.md
# Sample FIFO with Threshold Interrupt

This block buffers 16-bit conversion results that arrive on a valid/data input and hands them to a host over an 8-bit register port. The host fetches each result as two byte reads: the low byte first, which removes the sample from the queue, then the high byte, which comes from a holding register. A programmable fill threshold drives an interrupt request. A status register reports empty, threshold, full and overflow conditions. A control register holds the enable, scan-mode and clear bits.

With the queue enabled, the interrupt is a level that follows the threshold flag. With it disabled, the interrupt is a one-cycle pulse for every stored sample. In scan mode a small state machine counts the samples of one channel scan. It has two states. `SCAN_IDLE` is left for `SCAN_FILL` when a sample is stored with scan mode on and the scan is longer than one sample. `SCAN_FILL` returns to `SCAN_IDLE` when the last sample of the scan is stored, when scan mode is turned off, or when the queue is cleared. `busy` is high in `SCAN_FILL`. Interrupts are held back until a scan is complete.

Register map (3-bit address): 0 = data low byte (read), 1 = data high byte (read), 2 = threshold / depth main, 3 = threshold / depth extension, 4 = control (write) / status (read).

Top module: `sfq_top`

## Requirements
- R1: The queue holds up to 1024 16-bit samples in arrival order. A read of address 0 returns bits 7..0 of the oldest sample and removes it. A following read of address 1 returns bits 15..8 of that sample.
- R2: Writing address 2 sets threshold bits 8..1 and writing bit 0 of address 3 sets threshold bit 9. Threshold bit 0 is always 0. The threshold flag (status bit 1) is 1 when the queue is non-empty and its occupancy is at or above the threshold.
- R3: Status bit 2 (full) is 1 when 1024 samples are held. A sample that arrives while the queue is full is discarded, and status bit 3 (overflow) is set.
- R4: The overflow flag stays set until a read of address 0 finds the queue non-empty.
- R5: Status bit 0 (empty) is 1 when no sample is held. A read of address 0 in that state returns 0xFF and removes nothing. The next read of address 1 also returns 0xFF.
- R6: Writing address 4 with bit 2 set empties the queue, clears overflow and makes status empty=1, threshold=0, full=0. Writing bit 2 as 0 leaves the contents untouched.
- R7: With control bit 0 (enable) set and scan mode off, `irq` equals the threshold flag.
- R8: With enable clear and scan mode off, `irq` is high for exactly one cycle after each stored sample.
- R9: With control bit 1 (scan) set, `busy` rises when the first sample of a scan is stored. It falls when the last of `scan_len` samples is stored.
- R10: In scan mode, interrupts wait for a whole scan. With enable set, `irq` is the threshold flag masked while `busy`. With enable clear, a pulse occurs only when a scan completes.
- R11: Status reads back enable in bit 4, scan in bit 5, and in bits 7..6 the page selection written through control bits 7..6.
- R12: Reads of address 2 return occupancy bits 8..1. Reads of address 3 return occupancy bits 10..9 in bits 1..0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_valid | input | 1 | A conversion result is present |
| smp_data | input | 16 | Conversion result |
| scan_len | input | 6 | Samples per scan (0 and 1 both mean one) |
| bus_addr | input | 3 | Register address |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid while bus_rd is high |
| irq | output | 1 | Interrupt request |
| busy | output | 1 | Scan in progress |

## Verification
The assertions check several rules on every cycle. Occupancy never exceeds capacity. A sample dropped while the queue is full leaves the count unchanged and sets overflow. Overflow holds until a real pop. A clear always leaves the queue empty. `busy` falls once scan mode is turned off. The bench scenarios cover what needs a known history of pushes and pops. These include first-in-first-out ordering across the byte pair, the split threshold and depth layouts, the 0xFF reads of an empty queue, the one-cycle interrupt pulse, and the way a scan holds back interrupts.

// File: rtl/sfq_pkg.sv
package sfq_pkg;
    localparam int SMP_W = 16;
    localparam int BYTE_W = 8;

    typedef enum logic [0:0] {
        SCAN_IDLE = 1'b0,
        SCAN_FILL = 1'b1
    } scan_st_e;

    localparam logic [2:0] A_DLO  = 3'd0;
    localparam logic [2:0] A_DHI  = 3'd1;
    localparam logic [2:0] A_THR  = 3'd2;
    localparam logic [2:0] A_TEXT = 3'd3;
    localparam logic [2:0] A_CTRL = 3'd4;
endpackage

// File: rtl/sfq_store.sv
module sfq_store #(
    parameter int DEPTH = 1024,
    parameter int DW    = 16,
    localparam int AW   = $clog2(DEPTH),
    localparam int CW   = AW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          push,
    input  logic [DW-1:0] din,
    input  logic          pop,
    output logic [DW-1:0] head,
    output logic [CW-1:0] count,
    output logic          full,
    output logic          empty
);
    logic [DW-1:0] mem [DEPTH];
    logic [AW-1:0] wp, rp;
    logic          push_ok, pop_ok;

    assign full    = (count == CW'(DEPTH));
    assign empty   = (count == '0);
    assign push_ok = push && !full;
    assign pop_ok  = pop && !empty;
    assign head    = mem[rp];

    always_ff @(posedge clk) begin
        if (push_ok) mem[wp] <= din;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wp    <= '0;
            rp    <= '0;
            count <= '0;
        end else if (clr) begin
            wp    <= '0;
            rp    <= '0;
            count <= '0;
        end else begin
            if (push_ok) wp <= wp + 1'b1;
            if (pop_ok)  rp <= rp + 1'b1;
            count <= count + CW'(push_ok) - CW'(pop_ok);
        end
    end

    // R1
    count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CW'(DEPTH));

    // R3
    drop_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push && full && !pop && !clr) |=> (count == $past(count)));
endmodule

// File: rtl/sfq_scan.sv
module sfq_scan
    import sfq_pkg::*;
#(
    parameter int CHW = 6
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           clr,
    input  logic           scan_en,
    input  logic           stored,
    input  logic [CHW-1:0] scan_len,
    output logic           busy,
    output logic           done
);
    scan_st_e       st, st_nx;
    logic [CHW-1:0] cnt, cnt_nx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st  <= SCAN_IDLE;
            cnt <= '0;
        end else begin
            st  <= st_nx;
            cnt <= cnt_nx;
        end
    end

    always_comb begin
        st_nx  = st;
        cnt_nx = cnt;
        done   = 1'b0;
        unique case (st)
            SCAN_IDLE: begin
                if (!clr && scan_en && stored) begin
                    if (scan_len <= CHW'(1)) begin
                        done = 1'b1;
                    end else begin
                        st_nx  = SCAN_FILL;
                        cnt_nx = CHW'(1);
                    end
                end
            end
            SCAN_FILL: begin
                if (clr || !scan_en) begin
                    st_nx  = SCAN_IDLE;
                    cnt_nx = '0;
                end else if (stored) begin
                    if (cnt + CHW'(1) >= scan_len) begin
                        done   = 1'b1;
                        st_nx  = SCAN_IDLE;
                        cnt_nx = '0;
                    end else begin
                        cnt_nx = cnt + CHW'(1);
                    end
                end
            end
        endcase
    end

    assign busy = (st == SCAN_FILL);

    // R9
    busy_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !scan_en) |=> !busy);
endmodule

// File: rtl/sfq_top.sv
module sfq_top
    import sfq_pkg::*;
#(
    parameter int DEPTH = 1024,
    parameter int CHW   = 6,
    localparam int AW   = $clog2(DEPTH),
    localparam int CW   = AW + 1,
    localparam int XW   = AW - 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             smp_valid,
    input  logic [SMP_W-1:0] smp_data,
    input  logic [CHW-1:0]   scan_len,
    input  logic [2:0]       bus_addr,
    input  logic             bus_wr,
    input  logic             bus_rd,
    input  logic [7:0]       bus_wdata,
    output logic [7:0]       bus_rdata,
    output logic             irq,
    output logic             busy
);
    logic              ctl_en, ctl_scan, ovf, pulse;
    logic [1:0]        ctl_page;
    logic [7:0]        thr_lo, hold;
    logic [XW-1:0]     thr_hi;
    logic [SMP_W-1:0]  head;
    logic [CW-1:0]     count;
    logic              full, empty, clr, rd_lo, push_ok, done, thr_flag;
    logic [AW-1:0]     thr_val;

    assign clr      = bus_wr && (bus_addr == A_CTRL) && bus_wdata[2];
    assign rd_lo    = bus_rd && (bus_addr == A_DLO);
    assign push_ok  = smp_valid && !full && !clr;
    assign thr_val  = {thr_hi, thr_lo, 1'b0};
    assign thr_flag = !empty && (count >= {1'b0, thr_val});

    sfq_store #(.DEPTH(DEPTH), .DW(SMP_W)) u_store (
        .clk(clk), .rst_n(rst_n), .clr(clr),
        .push(smp_valid), .din(smp_data), .pop(rd_lo && !clr),
        .head(head), .count(count), .full(full), .empty(empty)
    );

    sfq_scan #(.CHW(CHW)) u_scan (
        .clk(clk), .rst_n(rst_n), .clr(clr), .scan_en(ctl_scan),
        .stored(push_ok), .scan_len(scan_len), .busy(busy), .done(done)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_en   <= 1'b0;
            ctl_scan <= 1'b0;
            ctl_page <= '0;
            thr_lo   <= '0;
            thr_hi   <= '0;
        end else if (bus_wr) begin
            unique case (bus_addr)
                A_THR:  thr_lo <= bus_wdata;
                A_TEXT: thr_hi <= bus_wdata[XW-1:0];
                A_CTRL: begin
                    ctl_en   <= bus_wdata[0];
                    ctl_scan <= bus_wdata[1];
                    ctl_page <= bus_wdata[7:6];
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hold  <= 8'hFF;
            ovf   <= 1'b0;
            pulse <= 1'b0;
        end else begin
            if (rd_lo) hold <= empty ? 8'hFF : head[2*BYTE_W-1:BYTE_W];
            if (clr)                   ovf <= 1'b0;
            else if (smp_valid && full) ovf <= 1'b1;
            else if (rd_lo && !empty)   ovf <= 1'b0;
            pulse <= !ctl_en && push_ok && (!ctl_scan || done);
        end
    end

    assign irq = ctl_en ? (thr_flag && (!ctl_scan || !busy)) : pulse;

    always_comb begin
        bus_rdata = 8'h00;
        case (bus_addr)
            A_DLO:  bus_rdata = empty ? 8'hFF : head[BYTE_W-1:0];
            A_DHI:  bus_rdata = hold;
            A_THR:  bus_rdata = count[8:1];
            A_TEXT: bus_rdata = {{(8-(CW-9)){1'b0}}, count[CW-1:9]};
            A_CTRL: bus_rdata = {ctl_page, ctl_scan, ctl_en, ovf, full, thr_flag, empty};
            default: bus_rdata = 8'h00;
        endcase
    end

    // R6
    clr_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (empty && !ovf));

    // R3
    ovf_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_valid && full && !clr) |=> ovf);

    // R4
    ovf_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf && !(rd_lo && !empty) && !clr) |=> ovf);

    // R5
    empty_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_lo && empty && !smp_valid) |=> (empty && hold == 8'hFF));
endmodule

// File: tb/sfq_top_test.sv
module sfq_top_test;
    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        smp_valid = 1'b0;
    logic [15:0] smp_data = '0;
    logic [5:0]  scan_len = 6'd1;
    logic [2:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [7:0]  bus_wdata = '0;
    logic [7:0]  bus_rdata;
    logic        irq, busy;

    int checks = 0;
    int fails  = 0;
    logic [15:0] exp_q[$];

    always #(CLK_P/2) clk = ~clk;

    sfq_top uut (
        .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_data(smp_data),
        .scan_len(scan_len), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq), .busy(busy)
    );

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    // driver: pushes a sample and records what should come back
    task automatic push(input logic [15:0] v, input bit keep);
        @(negedge clk);
        smp_valid = 1'b1; smp_data = v;
        @(negedge clk);
        smp_valid = 1'b0;
        if (keep) exp_q.push_back(v);
    endtask

    // monitor: reads a sample through the byte pair and compares with the queue
    task automatic pull(input string tag);
        logic [7:0] lo, hi;
        logic [15:0] exp;
        rd(3'd0, lo);
        rd(3'd1, hi);
        exp = (exp_q.size() == 0) ? 16'hFFFF : exp_q.pop_front();
        check(tag, {hi, lo}, exp);
    endtask

    task automatic chk_reg(input logic [2:0] a, input int exp, input string tag);
        logic [7:0] v;
        rd(a, v);
        check(tag, v, exp);
    endtask

    initial begin
        #(CLK_P * 200000);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        logic [7:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // reset state
        check("R5 reset irq", irq, 0);
        check("R9 reset busy", busy, 0);
        chk_reg(3'd4, 8'h01, "R5 reset status");

        // threshold 4, enabled
        wr(3'd2, 8'd2);
        wr(3'd4, 8'h01);
        for (int i = 0; i < 3; i++) push(16'h1234 + 16'(i * 16'h0101), 1);
        check("R7 below threshold irq", irq, 0);
        chk_reg(3'd4, 8'h10, "R2 below threshold status");
        push(16'hBEEF, 1);
        check("R7 at threshold irq", irq, 1);
        chk_reg(3'd4, 8'h12, "R2 at threshold status");
        chk_reg(3'd2, 8'h02, "R12 depth main");
        chk_reg(3'd3, 8'h00, "R12 depth ext");
        pull("R1 first sample");
        check("R7 irq after pop", irq, 0);
        for (int i = 0; i < 3; i++) pull("R1 order");

        // empty reads
        chk_reg(3'd0, 8'hFF, "R5 empty low");
        chk_reg(3'd1, 8'hFF, "R5 empty high");
        chk_reg(3'd4, 8'h11, "R5 empty status");

        // fill to capacity
        for (int i = 0; i < 1024; i++) push(16'(i * 37 + 5), 1);
        chk_reg(3'd4, 8'h16, "R3 full status");
        chk_reg(3'd3, 8'h02, "R12 full depth ext");
        chk_reg(3'd2, 8'h00, "R12 full depth main");
        push(16'hDEAD, 0);
        chk_reg(3'd4, 8'h1E, "R3 overflow status");
        chk_reg(3'd4, 8'h1E, "R4 overflow sticky");
        pull("R3 dropped sample absent, oldest first");
        chk_reg(3'd4, 8'h12, "R4 overflow cleared by read");
        wr(3'd4, 8'h01);
        chk_reg(3'd2, 8'hFF, "R6 clear bit 0 no effect main");
        chk_reg(3'd3, 8'h01, "R6 clear bit 0 no effect ext");
        pull("R6 contents kept");
        wr(3'd4, 8'h05);
        exp_q.delete();
        chk_reg(3'd4, 8'h11, "R6 cleared status");

        // threshold 512 via extension bit
        wr(3'd3, 8'h01);
        wr(3'd2, 8'h00);
        for (int i = 0; i < 511; i++) push(16'(i), 1);
        chk_reg(3'd4, 8'h10, "R2 ext threshold below");
        push(16'h0ABC, 1);
        chk_reg(3'd4, 8'h12, "R2 ext threshold reached");
        wr(3'd4, 8'h05);
        exp_q.delete();
        wr(3'd3, 8'h00);

        // disabled: pulse per sample
        wr(3'd4, 8'h00);
        push(16'h5555, 1);
        check("R8 pulse high", irq, 1);
        @(negedge clk);
        check("R8 pulse one cycle", irq, 0);
        wr(3'd4, 8'h04);
        exp_q.delete();

        // scan, disabled
        scan_len = 6'd3;
        wr(3'd4, 8'h02);
        push(16'h0001, 1);
        check("R9 busy after first", busy, 1);
        check("R10 no pulse mid scan", irq, 0);
        push(16'h0002, 1);
        check("R9 busy mid scan", busy, 1);
        check("R10 no pulse second", irq, 0);
        push(16'h0003, 1);
        check("R9 busy falls at end", busy, 0);
        check("R10 pulse at scan end", irq, 1);
        wr(3'd4, 8'h06);
        exp_q.delete();

        // scan, enabled, threshold 2, page 2
        wr(3'd2, 8'd1);
        wr(3'd4, 8'h83);
        push(16'hA001, 1);
        check("R10 enabled first", irq, 0);
        push(16'hA002, 1);
        check("R10 masked while busy", irq, 0);
        push(16'hA003, 1);
        check("R10 irq after whole scan", irq, 1);
        chk_reg(3'd4, 8'hB2, "R11 status readback");
        for (int i = 0; i < 3; i++) pull("R1 scan samples");

        summary();
        $finish;
    end
endmodule